// File: doc/BRIEF.md
# Primary Clock Fail-Safe Monitor and Source Switch

This block supervises an external primary clock against an internal reference oscillator that runs whenever the block is enabled. A sample clock is made by dividing the reference by a parameter (64 by default). Each sample period opens a detection window on its rising edge and closes it on its falling edge. If no falling edge of the primary arrives within a window while the block runs from the primary with monitoring enabled, the block declares a failure. It then moves the system clock back onto the reference, sets a sticky failure flag and sends a one-cycle reset pulse to the watchdog.

After reset the reference drives the system clock. Once the start-up timer reports the primary ready, the block hands the system clock over to the primary and sets the clock-status bit. A failover leaves that status bit set on purpose, so software can recognise the fail-safe condition because the status claims the primary while the reference actually runs. The fail-safe condition ends only on reset or on a power-managed-mode entry strobe. Either one sends the block back to its start-up path.

Top module: `clk_failsafe`

## Requirements
- R1: While reset is asserted, and after it until the primary is accepted, `fail_flag`, `wdt_rst` and `pri_active` are 0 and `sys_clk` follows `ref_clk`.
- R2: With the default two synchronizer stages, `pri_active` goes to 1 on the third rising `ref_clk` edge that samples `pri_ready` high while the block is in its start-up state. `sys_clk` then follows `pri_clk`.
- R3: While `pri_ready` stays 0, the block stays on the reference and `pri_active` stays 0 for as long as that lasts.
- R4: With `mon_en` at 1 and the block on the primary, a window from a sample-clock rising edge to the next falling edge that contains no primary falling edge sets `fail_flag`. When the primary stops, this happens within two sample periods.
- R5: `wdt_rst` is 1 for exactly one `ref_clk` cycle, and that cycle is the one in which `fail_flag` becomes 1 because of a failure.
- R6: After a failure `sys_clk` keeps toggling at the `ref_clk` rate, and `pri_active` stays 1.
- R7: While `mon_en` is 0, a stopped primary declares no failure and `pri_active` is not changed.
- R8: `fail_flag` holds at 1 until a one-cycle `flag_clr` strobe or reset clears it. A failure set in the same cycle as the strobe wins.
- R9: A `lp_entry` strobe in the fail-safe condition clears `pri_active` on the next `ref_clk` edge and returns the block to its start-up state, which waits again for `pri_ready`. Outside the fail-safe condition the strobe has no effect.
- R10: Switching between sources never produces a `sys_clk` high or low phase shorter than the shorter half period of the two clocks. The two source enables are never active together.
- R11: A primary that keeps running is never declared failed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously to `ref_clk` |
| ref_clk | input | 1 | Internal reference oscillator clock |
| pri_clk | input | 1 | External primary clock under supervision |
| mon_en | input | 1 | Enables monitoring and failover |
| pri_ready | input | 1 | Primary ready indication from the start-up timer (asynchronous) |
| lp_entry | input | 1 | Power-managed-mode entry strobe, `ref_clk` domain |
| flag_clr | input | 1 | Write-zero strobe for the failure flag, `ref_clk` domain |
| sys_clk | output | 1 | Selected system clock |
| fail_flag | output | 1 | Sticky oscillator-failure flag |
| wdt_rst | output | 1 | One-cycle watchdog and postscaler reset pulse |
| pri_active | output | 1 | Clock-status bit: primary accepted as system clock |

## Verification
The bench builds the block with `SAMPLE_DIV` = 16 and `SYNC_STAGES` = 2. This shortens a sample period to sixteen reference cycles, so several complete detection windows, two full failovers and a return through the start-up path fit into a short run. With two synchronizer stages the hand-over latency after `pri_ready` is exact, so the status bit can be compared cycle by cycle. The reference model accepts a failure anywhere inside the two-period deadline and checks the watchdog pulse in that exact cycle.

// File: rtl/cfm_pkg.sv
`timescale 1ns/1ps
package cfm_pkg;
  typedef enum logic [1:0] {
    CS_BOOT    = 2'd0,
    CS_PRIMARY = 2'd1,
    CS_SAFE    = 2'd2
  } clk_state_e;
endpackage

// File: rtl/cfm_sync_bit.sv
`timescale 1ns/1ps
module cfm_sync_bit #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] ff_q;
  logic [STAGES-1:0] ff_d;

  always_comb ff_d = {ff_q[STAGES-2:0], d};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ff_q <= {STAGES{RST_VAL}};
    else        ff_q <= ff_d;
  end

  assign q = ff_q[STAGES-1];
endmodule

// File: rtl/cfm_sampler.sv
`timescale 1ns/1ps
module cfm_sampler #(
  parameter int SAMPLE_DIV = 64
) (
  input  logic clk,
  input  logic rst_n,
  output logic smp_rise,
  output logic smp_fall
);
  localparam int CNT_W = $clog2(SAMPLE_DIV);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(SAMPLE_DIV - 1);
  localparam logic [CNT_W-1:0] HALF = CNT_W'(SAMPLE_DIV / 2);
  localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    if (cnt_q == LAST) cnt_d = '0;
    else               cnt_d = cnt_q + ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign smp_rise = (cnt_q == '0);
  assign smp_fall = (cnt_q == HALF);
endmodule

// File: rtl/cfm_edge_watch.sv
`timescale 1ns/1ps
module cfm_edge_watch #(
  parameter int STAGES = 2
) (
  input  logic pri_clk,
  input  logic pri_rst_n,
  input  logic ref_clk,
  input  logic rst_n,
  input  logic smp_rise,
  input  logic smp_fall,
  input  logic watch_en,
  output logic fail_det
);
  logic tog_q, tog_d, tog_s, tog_last_q, edge_hit;
  logic seen_q, seen_d, armed_q, armed_d, fail_q, fail_d;

  // primary domain: every falling edge flips a toggle bit
  always_comb tog_d = ~tog_q;

  always_ff @(negedge pri_clk or negedge pri_rst_n) begin
    if (!pri_rst_n) tog_q <= 1'b0;
    else            tog_q <= tog_d;
  end

  cfm_sync_bit #(.STAGES(STAGES), .RST_VAL(1'b0)) u_tog_sync (
    .clk   (ref_clk),
    .rst_n (rst_n),
    .d     (tog_q),
    .q     (tog_s)
  );

  // window latch: primary edge marks it, sample rise opens a fresh window
  always_comb begin
    edge_hit = tog_s ^ tog_last_q;
    if (smp_rise) seen_d = edge_hit;
    else          seen_d = seen_q | edge_hit;
    if (smp_rise) armed_d = watch_en;
    else          armed_d = armed_q & watch_en;
    fail_d = smp_fall & armed_q & watch_en & ~(seen_q | edge_hit);
  end

  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) begin
      tog_last_q <= 1'b0;
      seen_q     <= 1'b0;
      armed_q    <= 1'b0;
      fail_q     <= 1'b0;
    end else begin
      tog_last_q <= tog_s;
      seen_q     <= seen_d;
      armed_q    <= armed_d;
      fail_q     <= fail_d;
    end
  end

  assign fail_det = fail_q;

  // R4
  fail_after_fall_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
    fail_q |-> $past(smp_fall));
endmodule

// File: rtl/cfm_glitchless_mux.sv
`timescale 1ns/1ps
module cfm_glitchless_mux #(
  parameter int STAGES = 2
) (
  input  logic pri_clk,
  input  logic ref_clk,
  input  logic rst_n,
  input  logic pri_allow,
  output logic sys_clk
);
  logic pri_clk_n, ref_clk_n, pri_clr_n;
  logic pri_en, ref_en, pri_req, ref_req;

  assign pri_clk_n = ~pri_clk;
  assign ref_clk_n = ~ref_clk;
  // a withdrawn grant clears the primary side at once: its clock may be dead
  assign pri_clr_n = rst_n & pri_allow;
  assign pri_req   = ~ref_en;
  assign ref_req   = ~(pri_allow | pri_en);

  cfm_sync_bit #(.STAGES(STAGES), .RST_VAL(1'b0)) u_pri_hs (
    .clk   (pri_clk_n),
    .rst_n (pri_clr_n),
    .d     (pri_req),
    .q     (pri_en)
  );

  cfm_sync_bit #(.STAGES(STAGES), .RST_VAL(1'b1)) u_ref_hs (
    .clk   (ref_clk_n),
    .rst_n (rst_n),
    .d     (ref_req),
    .q     (ref_en)
  );

  assign sys_clk = (pri_clk & pri_en) | (ref_clk & ref_en);

  // R10
  enables_exclusive_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
    !(pri_en && ref_en));
endmodule

// File: rtl/cfm_ctrl.sv
`timescale 1ns/1ps
module cfm_ctrl
  import cfm_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic rdy_s,
  input  logic mon_en,
  input  logic lp_entry,
  input  logic flag_clr,
  input  logic fail_det,
  output logic watch_en,
  output logic pri_allow,
  output logic status,
  output logic fail_flag,
  output logic wdt_rst
);
  clk_state_e state_q, state_d;
  logic status_q, status_d;
  logic flag_q, flag_d, flag_set;
  logic wdt_q, wdt_d;
  logic allow_q, allow_d;

  always_comb begin
    state_d  = state_q;
    status_d = status_q;
    flag_set = 1'b0;
    wdt_d    = 1'b0;
    case (state_q)
      CS_BOOT: begin
        if (rdy_s) begin
          state_d  = CS_PRIMARY;
          status_d = 1'b1;
        end
      end
      CS_PRIMARY: begin
        if (fail_det) begin
          state_d  = CS_SAFE;
          flag_set = 1'b1;
          wdt_d    = 1'b1;
        end
      end
      CS_SAFE: begin
        if (lp_entry) begin
          state_d  = CS_BOOT;
          status_d = 1'b0;
        end
      end
      default: state_d = CS_BOOT;
    endcase
    flag_d  = flag_set | (flag_q & ~flag_clr);
    allow_d = (state_d == CS_PRIMARY);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= CS_BOOT;
      status_q <= 1'b0;
      flag_q   <= 1'b0;
      wdt_q    <= 1'b0;
      allow_q  <= 1'b0;
    end else begin
      state_q  <= state_d;
      status_q <= status_d;
      flag_q   <= flag_d;
      wdt_q    <= wdt_d;
      allow_q  <= allow_d;
    end
  end

  assign watch_en  = allow_q & mon_en;
  assign pri_allow = allow_q;
  assign status    = status_q;
  assign fail_flag = flag_q;
  assign wdt_rst   = wdt_q;

  // R5
  wdt_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_q |=> !wdt_q);
  // R5
  fail_wdt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == CS_PRIMARY && fail_det) |=> (wdt_q && flag_q));
  // R6
  status_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == CS_SAFE && !lp_entry) |=> $stable(status_q));
  // R8
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !flag_clr) |=> flag_q);
  // R9
  lp_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == CS_SAFE && lp_entry) |=> !status_q);
endmodule

// File: rtl/clk_failsafe.sv
`timescale 1ns/1ps
module clk_failsafe #(
  parameter int SAMPLE_DIV  = 64,
  parameter int SYNC_STAGES = 2
) (
  input  logic rst_n,
  input  logic ref_clk,
  input  logic pri_clk,
  input  logic mon_en,
  input  logic pri_ready,
  input  logic lp_entry,
  input  logic flag_clr,
  output logic sys_clk,
  output logic fail_flag,
  output logic wdt_rst,
  output logic pri_active
);
  logic srst_n, rdy_s, smp_rise, smp_fall, watch_en, fail_det, pri_allow;

  cfm_sync_bit #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_rst_sync (
    .clk   (ref_clk),
    .rst_n (rst_n),
    .d     (1'b1),
    .q     (srst_n)
  );

  cfm_sync_bit #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_rdy_sync (
    .clk   (ref_clk),
    .rst_n (srst_n),
    .d     (pri_ready),
    .q     (rdy_s)
  );

  cfm_sampler #(.SAMPLE_DIV(SAMPLE_DIV)) u_sampler (
    .clk      (ref_clk),
    .rst_n    (srst_n),
    .smp_rise (smp_rise),
    .smp_fall (smp_fall)
  );

  cfm_edge_watch #(.STAGES(SYNC_STAGES)) u_watch (
    .pri_clk   (pri_clk),
    .pri_rst_n (rst_n),
    .ref_clk   (ref_clk),
    .rst_n     (srst_n),
    .smp_rise  (smp_rise),
    .smp_fall  (smp_fall),
    .watch_en  (watch_en),
    .fail_det  (fail_det)
  );

  cfm_ctrl u_ctrl (
    .clk       (ref_clk),
    .rst_n     (srst_n),
    .rdy_s     (rdy_s),
    .mon_en    (mon_en),
    .lp_entry  (lp_entry),
    .flag_clr  (flag_clr),
    .fail_det  (fail_det),
    .watch_en  (watch_en),
    .pri_allow (pri_allow),
    .status    (pri_active),
    .fail_flag (fail_flag),
    .wdt_rst   (wdt_rst)
  );

  cfm_glitchless_mux #(.STAGES(SYNC_STAGES)) u_mux (
    .pri_clk   (pri_clk),
    .ref_clk   (ref_clk),
    .rst_n     (rst_n),
    .pri_allow (pri_allow),
    .sys_clk   (sys_clk)
  );
endmodule

// File: tb/test_clk_failsafe.sv
`timescale 1ns/1ps
module test_clk_failsafe;
  localparam int REF_PERIOD = 10;
  localparam int PRI_HALF   = 7;
  localparam int DIV        = 16;
  localparam int DEADLINE   = 2 * DIV;
  localparam int MIN_PHASE  = REF_PERIOD / 2;
  localparam int WIN        = 70;
  localparam int PRI_EDGES  = (WIN * REF_PERIOD) / (2 * PRI_HALF);

  logic rst_n = 1'b0, ref_clk = 1'b0, pri_clk = 1'b0;
  logic mon_en = 1'b0, pri_ready = 1'b0, lp_entry = 1'b0, flag_clr = 1'b0;
  logic sys_clk, fail_flag, wdt_rst, pri_active;

  bit pri_run = 1'b1;
  bit pri_stopped = 1'b0;
  bit gl_on = 1'b0;
  int vectors = 0;
  int miscompares = 0;
  int sys_edges = 0;
  time last_t = 0;

  clk_failsafe #(.SAMPLE_DIV(DIV), .SYNC_STAGES(2)) i_clk_failsafe (
    .rst_n      (rst_n),
    .ref_clk    (ref_clk),
    .pri_clk    (pri_clk),
    .mon_en     (mon_en),
    .pri_ready  (pri_ready),
    .lp_entry   (lp_entry),
    .flag_clr   (flag_clr),
    .sys_clk    (sys_clk),
    .fail_flag  (fail_flag),
    .wdt_rst    (wdt_rst),
    .pri_active (pri_active)
  );

  always #(REF_PERIOD / 2) ref_clk = ~ref_clk;
  always #(PRI_HALF) if (pri_run) pri_clk = ~pri_clk;

  task automatic chk(input string tag, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // R10: no short phase on the system clock
  always @(sys_clk) begin
    if (gl_on && rst_n) begin
      vectors++;
      if ($time - last_t < MIN_PHASE) begin
        miscompares++;
        $display("FAIL R10 short sys_clk phase: actual %0t expected >= %0d", $time - last_t, MIN_PHASE);
      end
    end
    last_t = $time;
  end

  always @(posedge sys_clk) sys_edges++;

  // behavioural reference model, compared every reference cycle
  int m_state = 0;
  bit m_status = 1'b0, m_flag = 1'b0, m_wdt = 1'b0;
  int rel_cnt = 0, wait_cnt = 0;
  bit rdy_q[$] = '{1'b0, 1'b0};

  always @(posedge ref_clk) begin
    if (!rst_n) begin
      m_state = 0; m_status = 1'b0; m_flag = 1'b0; m_wdt = 1'b0;
      rel_cnt = 0; wait_cnt = 0; rdy_q = '{1'b0, 1'b0};
    end else if (rel_cnt < 2) begin
      rel_cnt++;
    end else begin
      bit rdy_old;
      rdy_old = rdy_q.pop_front();
      rdy_q.push_back(pri_ready);
      m_wdt = 1'b0;
      case (m_state)
        0: if (rdy_old) begin m_state = 1; m_status = 1'b1; end
        1: if (pri_stopped && mon_en) wait_cnt++; else wait_cnt = 0;
        default: if (lp_entry) begin m_state = 0; m_status = 1'b0; end
      endcase
      if (flag_clr) m_flag = 1'b0;
    end
    #3;
    if (rst_n && m_state == 1) begin
      if (!m_flag && fail_flag && pri_stopped) begin
        m_state = 2; m_flag = 1'b1; m_wdt = 1'b1; wait_cnt = 0;
      end else if (wait_cnt > DEADLINE) begin
        chk("R4 failure deadline exceeded", 0, 1);
        m_state = 2; m_flag = 1'b1; wait_cnt = 0;
      end
    end
    chk("R4 R8 fail_flag model", fail_flag, m_flag);
    chk("R5 wdt_rst model", wdt_rst, m_wdt);
    chk("R2 R6 R9 pri_active model", pri_active, m_status);
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge ref_clk);
  endtask

  task automatic rate(input int n, input int exp, input string tag);
    int e0;
    int d;
    e0 = sys_edges;
    cyc(n);
    d = sys_edges - e0;
    vectors++;
    if (d < exp - 1 || d > exp + 1) begin
      miscompares++;
      $display("FAIL %s: actual %0d edges expected %0d", tag, d, exp);
    end
  endtask

  task automatic stop_pri();
    @(negedge pri_clk);
    pri_run = 1'b0;
    pri_stopped = 1'b1;
  endtask

  task automatic start_pri();
    pri_stopped = 1'b0;
    pri_run = 1'b1;
  endtask

  task automatic wait_fail();
    for (int i = 0; i < DEADLINE + 6; i++) begin
      if (fail_flag) break;
      cyc(1);
    end
  endtask

  initial begin
    repeat (200000) @(posedge ref_clk);
    miscompares++;
    $display("FAIL watchdog: run not finished, actual running expected done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    cyc(4);
    chk("R1 fail_flag in reset", fail_flag, 0);
    chk("R1 wdt_rst in reset", wdt_rst, 0);
    chk("R1 pri_active in reset", pri_active, 0);
    rate(WIN, WIN, "R1 sys_clk on reference in reset");
    rst_n = 1'b1;
    mon_en = 1'b1;
    cyc(5);
    gl_on = 1'b1;

    cyc(40);
    chk("R3 no ready keeps status", pri_active, 0);
    rate(WIN, WIN, "R3 sys_clk on reference without ready");

    pri_ready = 1'b1;
    cyc(2);
    chk("R2 status before third edge", pri_active, 0);
    cyc(1);
    chk("R2 status at third edge", pri_active, 1);
    cyc(20);
    rate(WIN, PRI_EDGES, "R2 sys_clk follows primary");

    cyc(5 * DIV);
    chk("R11 running primary not flagged", fail_flag, 0);

    lp_entry = 1'b1; cyc(1); lp_entry = 1'b0;
    cyc(3);
    chk("R9 lp_entry ignored on primary", pri_active, 1);
    rate(WIN, PRI_EDGES, "R9 still on primary after lp_entry");

    mon_en = 1'b0;
    stop_pri();
    cyc(4 * DIV);
    chk("R7 disabled monitor no failure", fail_flag, 0);
    chk("R7 disabled monitor status", pri_active, 1);

    mon_en = 1'b1;
    wait_fail();
    chk("R4 failure declared", fail_flag, 1);
    chk("R6 status unchanged after failover", pri_active, 1);
    cyc(10);
    rate(WIN, WIN, "R6 sys_clk toggles on reference");

    cyc(3 * DIV);
    chk("R8 flag sticky", fail_flag, 1);
    flag_clr = 1'b1; cyc(1); flag_clr = 1'b0;
    chk("R8 flag cleared by strobe", fail_flag, 0);
    cyc(2 * DIV);
    chk("R8 flag stays clear", fail_flag, 0);

    pri_ready = 1'b0;
    cyc(4);
    lp_entry = 1'b1; cyc(1); lp_entry = 1'b0;
    chk("R9 status cleared on exit", pri_active, 0);
    cyc(10);
    rate(WIN, WIN, "R9 reference after exit");
    start_pri();
    cyc(5);
    chk("R9 waits for ready again", pri_active, 0);
    pri_ready = 1'b1;
    cyc(10);
    chk("R2 primary accepted again", pri_active, 1);
    cyc(10);
    rate(WIN, PRI_EDGES, "R2 sys_clk on primary again");

    stop_pri();
    wait_fail();
    chk("R4 second failure declared", fail_flag, 1);
    chk("R6 status kept after second failover", pri_active, 1);
    cyc(10);
    rate(WIN, WIN, "R6 sys_clk on reference again");

    gl_on = 1'b0;
    rst_n = 1'b0;
    cyc(2);
    chk("R1 R8 reset clears flag", fail_flag, 0);
    chk("R1 reset clears status", pri_active, 0);
    chk("R1 reset clears wdt_rst", wdt_rst, 0);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule